// File: doc/BRIEF.md
# Programmable 16x Baud Tick Generator

This block turns a reference clock into a clock-enable pulse at sixteen times the serial bit rate. The transmitter and receiver of a serial port use this pulse to pace their work. The pulse rate is set by a 16-bit divisor, with divisor = reference frequency / (16 × baud). For example, a 1.8432 MHz reference gives 9600 baud with a divisor of 12 and 115200 baud with a divisor of 1. The divisor is held as two byte-wide latches, one for the low half and one for the high half.

Software reaches the latches through a small register port. The top bit of a line-setup register is the latch-select bit. While it is set, the two lowest addresses point at the divisor bytes. While it is clear, those addresses belong to the data-path registers elsewhere in the port, and the block only flags that the access is meant for another block. Writing either divisor byte restarts the count at once, so a new rate takes effect without waiting for the old period to end. A divisor of zero is not a valid rate, and the block keeps the tick low while the divisor is zero. Register access is a plain single-cycle strobe interface with no back-pressure: a write takes effect on the clock edge where the write strobe is high, and read data is valid in the same cycle as the read strobe.

Top module: `baud16_gen`

## Requirements
- R1: After reset the line-setup register reads 0x00, both divisor bytes are 0x00 and `tick16` is low.
- R2: Address 3 is the line-setup register. All 8 bits can be written and read back, and bit 7 is the latch-select bit.
- R3: While bit 7 of the line-setup register is 1, address 0 writes and reads the low divisor byte, and address 1 writes and reads the high divisor byte.
- R4: While bit 7 of the line-setup register is 0, a write to address 0 or 1 leaves both divisor bytes unchanged, and a read from address 0 or 1 returns 0x00.
- R5: For a divisor D of 2 or more, `tick16` is a pulse one cycle wide that repeats exactly every D cycles.
- R6: With a divisor of 1, `tick16` is high in every cycle.
- R7: With a divisor of 0, `tick16` stays low.
- R8: A write to either divisor byte restarts the count. If the write happens at clock edge W and the new divisor is D, the first tick is in the cycle that follows edge W+D-1.
- R9: `ext_sel` is high during a read or write to address 2 or to addresses 4–7. It is also high during a read or write to address 0 or 1 while the latch-select bit is 0. It is low in all other cases, including when no access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_addr | input | 3 | Register address |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid while `acc_rd` is high; 0x00 otherwise |
| ext_sel | output | 1 | The current access targets a register outside this block |
| latch_sel | output | 1 | Current value of the latch-select bit |
| tick16 | output | 1 | Clock-enable pulse at 16x the baud rate |

## Verification
The divider is exercised with several divisors:
- A small divisor (12) checks the period and the one-cycle pulse width.
- Divisor 1 checks the pass-through case.
- Divisor 256 has a zero low byte and a non-zero high byte. A broken byte lane shows up here as a wildly wrong period.
- Divisor 0 checks that the output stays silent.

A scoreboard compares the cycle of every tick against a predicted schedule. Each schedule is anchored at the last divisor write. A second write in the middle of a period separates a counter that restarts from one that finishes its old period first. Accesses made while the latch-select bit is clear, and to addresses this block does not own, show whether the address decode honours the select bit.

// File: rtl/baud16_pkg.sv
package baud16_pkg;
  // Register addresses decoded by the generator
  localparam int DIV_BASE_ADR = 0;  // divisor byte k sits at DIV_BASE_ADR + k
  localparam int LINE_SET_ADR = 3;  // line-setup register
endpackage

// File: rtl/bgen_regs.sv
module bgen_regs #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int NBYTES = 2,
  localparam int DIV_W = DATA_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              ext_sel,
  output logic              latch_sel,
  output logic [DIV_W-1:0]  div_q,
  output logic [DIV_W-1:0]  div_next,
  output logic              div_load
);
  import baud16_pkg::*;

  logic [DATA_W-1:0] line_set_q;
  logic [NBYTES-1:0] byte_hit;
  logic              hit_line;
  logic              owns_addr;

  assign latch_sel = line_set_q[DATA_W-1];
  assign hit_line  = (acc_addr == ADDR_W'(LINE_SET_ADR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                line_set_q <= '0;
    else if (acc_wr && hit_line) line_set_q <= acc_wdata;
  end

  // One byte latch per divisor slice
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign byte_hit[i] = acc_wr && latch_sel &&
                         (acc_addr == ADDR_W'(DIV_BASE_ADR + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           div_q[i*DATA_W +: DATA_W] <= '0;
      else if (byte_hit[i]) div_q[i*DATA_W +: DATA_W] <= acc_wdata;
    end
  end

  // Divisor value as it will stand after this edge
  always_comb begin
    div_next = div_q;
    for (int k = 0; k < NBYTES; k++)
      if (byte_hit[k]) div_next[k*DATA_W +: DATA_W] = acc_wdata;
  end

  assign div_load = |byte_hit;

  always_comb begin
    acc_rdata = '0;
    if (acc_rd) begin
      if (hit_line) acc_rdata = line_set_q;
      for (int k = 0; k < NBYTES; k++)
        if (latch_sel && acc_addr == ADDR_W'(DIV_BASE_ADR + k))
          acc_rdata = div_q[k*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    owns_addr = hit_line;
    for (int k = 0; k < NBYTES; k++)
      if (latch_sel && acc_addr == ADDR_W'(DIV_BASE_ADR + k)) owns_addr = 1'b1;
  end

  assign ext_sel = (acc_wr || acc_rd) && !owns_addr;

  // R4: a write with the select bit clear leaves the divisor alone
  a_r4_div_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !latch_sel) |=> $stable(div_q));

  // R9: the line-setup register is never flagged as foreign
  a_r9_line_owned: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_wr || acc_rd) && hit_line) |-> !ext_sel);
endmodule

// File: rtl/bgen_count.sv
module bgen_count #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_q,
  input  logic [DIV_W-1:0] div_next,
  input  logic             div_load,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (div_load)         cnt_q <= (div_next == '0) ? '0 : div_next - DIV_W'(1);
    else if (div_q == '0)      cnt_q <= '0;
    else if (cnt_q == '0)      cnt_q <= div_q - DIV_W'(1);
    else                       cnt_q <= cnt_q - DIV_W'(1);
  end

  assign tick = (div_q != '0) && (cnt_q == '0);

  // R7: zero divisor keeps the output silent
  a_r7_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |-> !tick);

  // R5: pulses are one cycle wide for divisors above one
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_q > DIV_W'(1) && !div_load) |=> !tick);

  // R6: divisor one ticks every cycle
  a_r6_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == DIV_W'(1) && !div_load) |=> tick);

  // R8: a reload to a divisor above one starts a fresh period
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (div_load && div_next > DIV_W'(1)) |=> !tick);
endmodule

// File: rtl/baud16_gen.sv
module baud16_gen #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int NBYTES = 2,
  localparam int DIV_W = DATA_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              ext_sel,
  output logic              latch_sel,
  output logic              tick16
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_next;
  logic             div_load;

  bgen_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBYTES(NBYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wr(acc_wr),
    .acc_rd(acc_rd), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .ext_sel(ext_sel), .latch_sel(latch_sel), .div_q(div_q),
    .div_next(div_next), .div_load(div_load)
  );

  bgen_count #(.DIV_W(DIV_W)) u_count (
    .clk(clk), .rst_n(rst_n), .div_q(div_q), .div_next(div_next),
    .div_load(div_load), .tick(tick16)
  );
endmodule

// File: tb/baud16_gen_tb.sv
module baud16_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] acc_addr = '0;
  logic       acc_wr = 1'b0;
  logic       acc_rd = 1'b0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] acc_rdata;
  logic       ext_sel;
  logic       latch_sel;
  logic       tick16;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit mon_en  = 1'b0;
  int exp_q[$];
  string mon_req = "R5";

  baud16_gen u_dut (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wr(acc_wr),
    .acc_rd(acc_rd), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .ext_sel(ext_sel), .latch_sel(latch_sel), .tick16(tick16)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: pops the expected tick cycle and compares
  always begin
    @(posedge clk);
    #5;
    if (mon_en && tick16) begin
      if (exp_q.size() == 0) chk(mon_req, cyc, -1);
      else chk(mon_req, cyc, exp_q.pop_front());
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d, output int w);
    @(negedge clk);
    acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0;
    w = cyc;
  endtask

  task automatic reg_read(input logic [2:0] a, output int d, output int sel);
    @(negedge clk);
    acc_addr = a; acc_rd = 1'b1;
    #1;
    d = acc_rdata; sel = ext_sel;
    acc_rd = 1'b0;
  endtask

  // Driver side: push the predicted schedule, run a window, check leftovers
  task automatic run_window(string req, int first, int period, int ncyc);
    int win_end;
    win_end = cyc + ncyc;
    exp_q.delete();
    for (int t = first; t <= win_end; t += period) exp_q.push_back(t);
    mon_req = req;
    mon_en = 1'b1;
    repeat (ncyc) @(negedge clk);
    mon_en = 1'b0;
    chk({req, " leftover"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    #3_000_000;
    n_fail++; n_tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int w, d, s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tick", tick16, 0);
    reg_read(3, d, s); chk("R1 line", d, 0);
    chk("R1 select", latch_sel, 0);

    // R2 line-setup read/write
    reg_write(3, 8'h83, w);
    reg_read(3, d, s); chk("R2 readback", d, 8'h83);
    chk("R2 select", latch_sel, 1);
    reg_read(0, d, s); chk("R1 div lo", d, 0);
    reg_read(1, d, s); chk("R1 div hi", d, 0);

    // R3/R5/R8 divisor 12
    reg_write(1, 8'h00, w);
    reg_write(0, 8'd12, w);
    reg_read(0, d, s); chk("R3 lo", d, 12);
    reg_read(1, d, s); chk("R3 hi", d, 0);
    run_window("R5", w + 11, 12, 60);

    // R6 divisor 1
    reg_write(0, 8'd1, w);
    run_window("R6", w + 1, 1, 20);

    // R3/R5 divisor 256 (high byte lane)
    reg_write(1, 8'h01, w);
    reg_write(0, 8'h00, w);
    reg_read(1, d, s); chk("R3 hi lane", d, 1);
    run_window("R5 256", w + 255, 256, 600);

    // R8 restart mid-period
    reg_write(1, 8'h00, w);
    reg_write(0, 8'd5, w);
    @(negedge clk); @(negedge clk);
    reg_write(0, 8'd5, w);
    run_window("R8", w + 4, 5, 30);

    // R7 divisor 0
    reg_write(0, 8'd0, w);
    run_window("R7", 1_000_000, 1, 100);
    chk("R7 tick low", tick16, 0);

    // R4 select bit clear
    reg_write(0, 8'd9, w);
    reg_write(3, 8'h03, w);
    @(negedge clk);
    acc_addr = 3'd0; acc_wdata = 8'h77; acc_wr = 1'b1;
    #1 chk("R9 wr addr0 clear", ext_sel, 1);
    @(negedge clk); acc_wr = 1'b0;
    reg_write(1, 8'h55, w);
    reg_read(0, d, s); chk("R4 read zero", d, 0); chk("R9 rd addr0 clear", s, 1);
    reg_write(3, 8'h80, w);
    reg_read(0, d, s); chk("R4 lo kept", d, 9); chk("R9 owned lo", s, 0);
    reg_read(1, d, s); chk("R4 hi kept", d, 0);

    // R9 foreign addresses and idle
    reg_read(2, d, s); chk("R9 addr2", s, 1);
    reg_read(5, d, s); chk("R9 addr5", s, 1);
    reg_read(3, d, s); chk("R9 addr3", s, 0);
    @(negedge clk); chk("R9 idle", ext_sel, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule